// File: doc/BRIEF.md
# Descriptor-Driven Transfer Engine

This block moves data on a simple memory bus under the control of descriptors that sit in that same memory. An activation, either a pulse on a hardware request line or a software trigger, makes the engine fetch a seven-word descriptor from `desc_base`. It then performs one transfer step and writes the updated addresses and counts back into the descriptor. If the descriptor's chain flag is set, the engine continues with the next descriptor, 16 bytes further on, before it goes idle again.

A step moves one byte or one 16-bit word in normal and repeat modes, and a whole block of units in block mode. Each address can be held, incremented or decremented. In repeat mode, one side is a repeat area that is rewound to its start when the count runs out. In block mode, one side is a block area that is rewound to its start after every block. When a normal or block count runs out, or when the descriptor asks for notification, a one-cycle CPU interrupt pulse marks the end of the activation.

Top module: `desc_xfer_engine`

## Requirements
- R1: While reset is held, and in the first cycle after it, `busy`, `irq`, `bus_rd` and `bus_wr` are low.
- R2: A one-cycle pulse on `act_req` or on `sw_trig` starts an activation at `desc_base`. `busy` rises and a descriptor read is issued in the same cycle. `busy` stays high until the cycle after the final write-back, and it does not drop between chained descriptors.
- R3: Descriptor layout, with 16-bit little-endian words at these byte offsets. Offset 0 is control: bits 1:0 source address mode, 3:2 destination address mode, 5:4 transfer mode (0 normal, 1 repeat, 2 block), 6 word unit, 7 area side (0 source, 1 destination), 8 chain, 9 notify. Offset 2 holds address bits 23:16 of the source and offset 4 bits 15:0; offsets 6 and 8 hold the same for the destination. Offset 10 is count A and offset 12 is count B. Offsets 2 to 12 are written back after each step.
- R4: Address modes: 0 and 3 hold the address, 1 adds the unit size and 2 subtracts it, where the unit size is 1 for bytes and 2 for words. Word units move 16 bits on the bus.
- R5: In normal mode, one unit moves per activation and count A is decremented. A count of 0 stands for 65,536 and is written back as 0xFFFF.
- R6: In repeat mode, one unit moves per activation and the low byte of count A is decremented. When it reaches 0, the low byte is reloaded from the high byte (0 means 256), and the repeat-area address returns to its start value.
- R7: In block mode, one activation moves as many units as the low byte of count A gives. The low byte is then reloaded from the high byte, the block-area address returns to its start, the other address keeps its stepped value, and count B is decremented.
- R8: When the chain flag is set, the descriptor 16 bytes further on is processed in the same activation.
- R9: `irq` pulses for exactly one cycle, in the cycle where `busy` falls. It does so if, during the activation, a normal count A or a block count B reached 0, or a descriptor with notify set was processed. Expiry in repeat mode never raises it.
- R10: Read data is expected one cycle after `bus_rd`, with bytes on bits 7:0. `bus_rd` and `bus_wr` are never high together, and neither is high while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| act_req | input | 1 | Hardware activation pulse |
| sw_trig | input | 1 | Software activation pulse |
| desc_base | input | 24 | Byte address of the first descriptor |
| busy | output | 1 | Activation in progress |
| irq | output | 1 | One-cycle CPU interrupt pulse |
| bus_rd | output | 1 | Memory read strobe |
| bus_wr | output | 1 | Memory write strobe |
| bus_word | output | 1 | Access is 16-bit (else byte) |
| bus_addr | output | 24 | Memory byte address |
| bus_wdata | output | 16 | Write data |
| bus_rdata | input | 16 | Read data, one cycle after the read strobe |

## Verification
The bench targets the count encodings: a zero count must wrap to 0xFFFF rather than expire, so a design that treats zero as "done" raises a spurious interrupt. It runs two repeat activations so the count expires, catching a design that fails to rewind the repeat area or that interrupts on repeat expiry. In block mode it checks that only the block-area address comes back to its start while the other advances by the block length; swapping the sides or rewinding both shows up in the written-back addresses. A chained pair checks that `busy` falls only once per activation and that both descriptors are updated, and a notify-only case checks that an interrupt is raised without any count expiring.

// File: rtl/dxe_pkg.sv
package dxe_pkg;

  typedef enum logic [1:0] {
    AM_FIXED = 2'b00,
    AM_INC   = 2'b01,
    AM_DEC   = 2'b10,
    AM_HOLD  = 2'b11
  } addr_mode_e;

  typedef enum logic [1:0] {
    XM_NORMAL = 2'b00,
    XM_REPEAT = 2'b01,
    XM_BLOCK  = 2'b10,
    XM_RSVD   = 2'b11
  } xfer_mode_e;

  // control word, bit 9 down to bit 0
  typedef struct packed {
    logic       notify;
    logic       chain;
    logic       area_dst;
    logic       word;
    xfer_mode_e xmode;
    addr_mode_e dmode;
    addr_mode_e smode;
  } ctl_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_DESC,
    S_XRD,
    S_XWR,
    S_WB
  } state_e;

endpackage

// File: rtl/dxe_act_latch.sv
module dxe_act_latch (
  input  logic clk,
  input  logic rst,
  input  logic hw_req,
  input  logic sw_req,
  input  logic take,
  output logic pending
);

  always_ff @(posedge clk) begin
    if (rst) pending <= 1'b0;
    else     pending <= (pending & ~take) | hw_req | sw_req;
  end

endmodule

// File: rtl/dxe_addr_step.sv
module dxe_addr_step
  import dxe_pkg::*;
#(
  parameter int AW = 24,
  parameter int SW = 9
) (
  input  logic [AW-1:0] addr,
  input  addr_mode_e    mode,
  input  logic          word,
  input  logic [SW-1:0] span,
  output logic [AW-1:0] stepped,
  output logic [AW-1:0] rewound
);

  logic [AW-1:0] unit_sz;
  logic [AW-1:0] span_bytes;

  always_comb begin
    unit_sz    = word ? AW'(2) : AW'(1);
    span_bytes = word ? AW'({span, 1'b0}) : AW'(span);
    unique case (mode)
      AM_INC: begin
        stepped = addr + unit_sz;
        rewound = stepped - span_bytes;
      end
      AM_DEC: begin
        stepped = addr - unit_sz;
        rewound = stepped + span_bytes;
      end
      default: begin
        stepped = addr;
        rewound = addr;
      end
    endcase
  end

endmodule

// File: rtl/dxe_count_unit.sv
module dxe_count_unit
  import dxe_pkg::*;
#(
  parameter int CW = 16
) (
  input  xfer_mode_e    xmode,
  input  logic [CW-1:0] cnt_a,
  input  logic [CW-1:0] cnt_b,
  output logic [CW-1:0] cnt_a_nxt,
  output logic [CW-1:0] cnt_b_nxt,
  output logic          wrap,
  output logic          expired,
  output logic          last
);

  localparam int H = CW / 2;

  logic [CW-1:0] a_dec;
  logic [CW-1:0] b_dec;
  logic [H-1:0]  lo_dec;

  always_comb begin
    a_dec     = cnt_a - CW'(1);
    b_dec     = cnt_b - CW'(1);
    lo_dec    = cnt_a[H-1:0] - H'(1);
    cnt_a_nxt = a_dec;
    cnt_b_nxt = cnt_b;
    wrap      = 1'b0;
    expired   = 1'b0;
    last      = 1'b1;
    unique case (xmode)
      XM_REPEAT: begin
        wrap      = (lo_dec == '0);
        cnt_a_nxt = {cnt_a[CW-1:H], wrap ? cnt_a[CW-1:H] : lo_dec};
      end
      XM_BLOCK: begin
        wrap      = (lo_dec == '0);
        cnt_a_nxt = {cnt_a[CW-1:H], wrap ? cnt_a[CW-1:H] : lo_dec};
        last      = wrap;
        if (wrap) begin
          cnt_b_nxt = b_dec;
          expired   = (b_dec == '0);
        end
      end
      default: expired = (a_dec == '0);
    endcase
  end

endmodule

// File: rtl/desc_xfer_engine.sv
module desc_xfer_engine
  import dxe_pkg::*;
#(
  parameter int AW     = 24,
  parameter int DW     = 16,
  parameter int STRIDE = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          act_req,
  input  logic          sw_trig,
  input  logic [AW-1:0] desc_base,
  output logic          busy,
  output logic          irq,
  output logic          bus_rd,
  output logic          bus_wr,
  output logic          bus_word,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata
);

  localparam int HIW     = AW - DW;
  localparam int HALF    = DW / 2;
  localparam int NWORDS  = 7;
  localparam int IDXW    = $clog2(NWORDS + 1);
  localparam int WB_LAST = NWORDS - 2;
  localparam int CTLW    = $bits(ctl_t);

  state_e         st;
  logic [IDXW-1:0] idx;
  logic [AW-1:0]  base_q;
  ctl_t           ctl_q;
  logic [AW-1:0]  src_q, dst_q;
  logic [DW-1:0]  ca_q, cb_q;
  logic           busy_q, irq_q, irq_pend;

  logic           pend, take;
  logic [HALF:0]  span;
  logic [AW-1:0]  src_step, src_rew, dst_step, dst_rew;
  logic [DW-1:0]  ca_nxt, cb_nxt;
  logic           wrap, expired, last;
  logic           rew_src, rew_dst;
  logic [DW-1:0]  wb_data;
  logic [AW-1:0]  idx_off;

  assign take = (st == S_IDLE) && pend;

  dxe_act_latch u_latch (
    .clk     (clk),
    .rst     (rst),
    .hw_req  (act_req),
    .sw_req  (sw_trig),
    .take    (take),
    .pending (pend)
  );

  // reload span in units: high byte of count A, zero meaning full range
  assign span = (ca_q[DW-1:HALF] == '0) ? (HALF+1)'(1 << HALF)
                                         : {1'b0, ca_q[DW-1:HALF]};

  dxe_addr_step #(.AW(AW), .SW(HALF+1)) u_src_step (
    .addr    (src_q),
    .mode    (ctl_q.smode),
    .word    (ctl_q.word),
    .span    (span),
    .stepped (src_step),
    .rewound (src_rew)
  );

  dxe_addr_step #(.AW(AW), .SW(HALF+1)) u_dst_step (
    .addr    (dst_q),
    .mode    (ctl_q.dmode),
    .word    (ctl_q.word),
    .span    (span),
    .stepped (dst_step),
    .rewound (dst_rew)
  );

  dxe_count_unit #(.CW(DW)) u_count (
    .xmode     (ctl_q.xmode),
    .cnt_a     (ca_q),
    .cnt_b     (cb_q),
    .cnt_a_nxt (ca_nxt),
    .cnt_b_nxt (cb_nxt),
    .wrap      (wrap),
    .expired   (expired),
    .last      (last)
  );

  assign rew_src = wrap && !ctl_q.area_dst;
  assign rew_dst = wrap &&  ctl_q.area_dst;
  assign idx_off = AW'({idx, 1'b0});

  always_comb begin
    unique case (idx)
      IDXW'(0): wb_data = DW'(src_q[AW-1:DW]);
      IDXW'(1): wb_data = src_q[DW-1:0];
      IDXW'(2): wb_data = DW'(dst_q[AW-1:DW]);
      IDXW'(3): wb_data = dst_q[DW-1:0];
      IDXW'(4): wb_data = ca_q;
      default:  wb_data = cb_q;
    endcase
  end

  always_comb begin
    bus_rd    = ((st == S_DESC) && (idx < IDXW'(NWORDS))) || (st == S_XRD);
    bus_wr    = (st == S_XWR) || (st == S_WB);
    bus_word  = ((st == S_DESC) || (st == S_WB)) ? 1'b1 : ctl_q.word;
    bus_addr  = '0;
    bus_wdata = '0;
    unique case (st)
      S_DESC: bus_addr = base_q + idx_off;
      S_XRD:  bus_addr = src_q;
      S_XWR: begin
        bus_addr  = dst_q;
        bus_wdata = ctl_q.word ? bus_rdata : {{(DW-HALF){1'b0}}, bus_rdata[HALF-1:0]};
      end
      S_WB: begin
        bus_addr  = base_q + idx_off + AW'(2);
        bus_wdata = wb_data;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      idx      <= '0;
      base_q   <= '0;
      ctl_q    <= '0;
      src_q    <= '0;
      dst_q    <= '0;
      ca_q     <= '0;
      cb_q     <= '0;
      busy_q   <= 1'b0;
      irq_q    <= 1'b0;
      irq_pend <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      unique case (st)
        S_IDLE: if (pend) begin
          st       <= S_DESC;
          idx      <= '0;
          busy_q   <= 1'b1;
          base_q   <= desc_base;
          irq_pend <= 1'b0;
        end
        S_DESC: begin
          // word idx-1 arrives while word idx is requested
          unique case (idx)
            IDXW'(1): ctl_q             <= ctl_t'(bus_rdata[CTLW-1:0]);
            IDXW'(2): src_q[AW-1:DW]    <= bus_rdata[HIW-1:0];
            IDXW'(3): src_q[DW-1:0]     <= bus_rdata;
            IDXW'(4): dst_q[AW-1:DW]    <= bus_rdata[HIW-1:0];
            IDXW'(5): dst_q[DW-1:0]     <= bus_rdata;
            IDXW'(6): ca_q              <= bus_rdata;
            IDXW'(7): cb_q              <= bus_rdata;
            default: ;
          endcase
          if (idx == IDXW'(NWORDS)) st <= S_XRD;
          else                      idx <= idx + IDXW'(1);
        end
        S_XRD: st <= S_XWR;
        S_XWR: begin
          src_q <= rew_src ? src_rew : src_step;
          dst_q <= rew_dst ? dst_rew : dst_step;
          ca_q  <= ca_nxt;
          cb_q  <= cb_nxt;
          if (expired || (ctl_q.notify && last)) irq_pend <= 1'b1;
          if (last) begin
            st  <= S_WB;
            idx <= '0;
          end else begin
            st  <= S_XRD;
          end
        end
        S_WB: begin
          if (idx == IDXW'(WB_LAST)) begin
            if (ctl_q.chain) begin
              st     <= S_DESC;
              idx    <= '0;
              base_q <= base_q + AW'(STRIDE);
            end else begin
              st     <= S_IDLE;
              busy_q <= 1'b0;
              irq_q  <= irq_pend;
            end
          end else begin
            idx <= idx + IDXW'(1);
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy = busy_q;
  assign irq  = irq_q;

endmodule

// File: rtl/desc_xfer_engine_chk.sv
module desc_xfer_engine_chk (
  input logic clk,
  input logic rst,
  input logic busy,
  input logic irq,
  input logic bus_rd,
  input logic bus_wr
);

  logic rst_d;
  always @(posedge clk) rst_d <= rst;

  // R1: registers cleared once reset has been seen at an edge
  always @(negedge clk) begin
    if (rst_d) begin
      p_reset_quiet_r1: assert (!busy && !irq && !bus_rd && !bus_wr);
    end
  end

  // R2: the first descriptor read starts with busy
  p_first_read_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> bus_rd);

  // R10: strobes exclusive
  p_rdwr_excl_r10: assert property (@(posedge clk) disable iff (rst)
    !(bus_rd && bus_wr));

  // R10: no bus traffic while idle
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    (bus_rd || bus_wr) |-> busy);

  // R9: interrupt only as busy falls
  p_irq_at_end_r9: assert property (@(posedge clk) disable iff (rst)
    irq |-> (!busy && $past(busy)));

  // R9: interrupt lasts a single cycle
  p_irq_single_r9: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);

endmodule

bind desc_xfer_engine desc_xfer_engine_chk u_chk (
  .clk    (clk),
  .rst    (rst),
  .busy   (busy),
  .irq    (irq),
  .bus_rd (bus_rd),
  .bus_wr (bus_wr)
);

// File: tb/desc_xfer_engine_tb.sv
module desc_xfer_engine_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        act_req = 1'b0;
  logic        sw_trig = 1'b0;
  logic [23:0] desc_base = 24'h000100;
  logic        busy, irq, bus_rd, bus_wr, bus_word;
  logic [23:0] bus_addr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata = '0;

  logic [7:0]  mem [0:4095];
  int checks = 0;
  int errors = 0;
  int irq_cnt = 0;
  int fall_cnt = 0;
  logic busy_prev = 1'b0;

  always #10 clk = ~clk;

  desc_xfer_engine u_dut (
    .clk       (clk),
    .rst       (rst),
    .act_req   (act_req),
    .sw_trig   (sw_trig),
    .desc_base (desc_base),
    .busy      (busy),
    .irq       (irq),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_word  (bus_word),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata)
  );

  // memory model: one-cycle read latency, little-endian words
  always @(posedge clk) begin
    if (bus_rd)
      bus_rdata <= bus_word ? {mem[12'(bus_addr[11:0] + 12'd1)], mem[bus_addr[11:0]]}
                            : {8'h00, mem[bus_addr[11:0]]};
    if (bus_wr) begin
      mem[bus_addr[11:0]] = bus_wdata[7:0];
      if (bus_word) mem[12'(bus_addr[11:0] + 12'd1)] = bus_wdata[15:8];
    end
  end

  always @(posedge clk) begin
    if (irq) irq_cnt <= irq_cnt + 1;
    if (busy_prev && !busy) fall_cnt <= fall_cnt + 1;
    busy_prev <= busy;
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not complete, got timeout expected completion");
    summary();
    $finish;
  end

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic put16(input int a, input logic [15:0] v);
    mem[a]     = v[7:0];
    mem[a + 1] = v[15:8];
  endtask

  function automatic logic [15:0] get16(input int a);
    return {mem[a + 1], mem[a]};
  endfunction

  task automatic make_desc(input int at, input logic [15:0] ctl,
                           input logic [23:0] s, input logic [23:0] d,
                           input logic [15:0] ca, input logic [15:0] cb);
    put16(at,      ctl);
    put16(at + 2,  {8'h00, s[23:16]});
    put16(at + 4,  s[15:0]);
    put16(at + 6,  {8'h00, d[23:16]});
    put16(at + 8,  d[15:0]);
    put16(at + 10, ca);
    put16(at + 12, cb);
  endtask

  task automatic fire(input bit use_sw);
    @(negedge clk);
    if (use_sw) sw_trig = 1'b1; else act_req = 1'b1;
    @(negedge clk);
    sw_trig = 1'b0;
    act_req = 1'b0;
    while (!busy) @(negedge clk);
    while (busy)  @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1", "busy after reset", 32'(busy), 32'd0);
    check("R1", "irq after reset", 32'(irq), 32'd0);
    check("R1", "strobes after reset", 32'({bus_rd, bus_wr}), 32'd0);
  endtask

  task automatic t_normal_byte();
    int i0;
    i0 = irq_cnt;
    make_desc(32'h100, 16'h0005, 24'h000400, 24'h000800, 16'd2, 16'd0);
    mem[12'h400] = 8'hA5;
    mem[12'h401] = 8'h3C;
    fire(1'b0);
    check("R5", "first byte moved", 32'(mem[12'h800]), 32'hA5);
    check("R4", "source stepped +1", 32'(get16(32'h104)), 32'h0401);
    check("R4", "destination stepped +1", 32'(get16(32'h108)), 32'h0801);
    check("R3", "count A written back", 32'(get16(32'h10A)), 32'd1);
    check("R9", "no irq before expiry", 32'(irq_cnt - i0), 32'd0);
    fire(1'b0);
    check("R5", "second byte moved", 32'(mem[12'h801]), 32'h3C);
    check("R5", "count reached zero", 32'(get16(32'h10A)), 32'd0);
    check("R9", "irq on normal expiry", 32'(irq_cnt - i0), 32'd1);
  endtask

  task automatic t_word_dec_sw();
    make_desc(32'h100, 16'h0042, 24'h000410, 24'h000810, 16'd5, 16'd0);
    put16(32'h410, 16'h1234);
    fire(1'b1);
    check("R2", "software trigger moves word", 32'(get16(32'h810)), 32'h1234);
    check("R4", "word source decrement by 2", 32'(get16(32'h104)), 32'h040E);
    check("R4", "held destination", 32'(get16(32'h108)), 32'h0810);
    check("R3", "source high byte written back", 32'(get16(32'h102)), 32'h0000);
  endtask

  task automatic t_zero_count();
    int i0;
    i0 = irq_cnt;
    make_desc(32'h100, 16'h0005, 24'h000418, 24'h000818, 16'd0, 16'd0);
    fire(1'b0);
    check("R5", "zero count wraps to 0xFFFF", 32'(get16(32'h10A)), 32'h0000FFFF);
    check("R9", "zero count gives no irq", 32'(irq_cnt - i0), 32'd0);
  endtask

  task automatic t_repeat();
    int i0;
    i0 = irq_cnt;
    make_desc(32'h100, 16'h0094, 24'h000420, 24'h000820, 16'h0202, 16'd0);
    fire(1'b0);
    check("R6", "repeat area stepped", 32'(get16(32'h108)), 32'h0821);
    check("R6", "repeat count low byte", 32'(get16(32'h10A)), 32'h0201);
    fire(1'b0);
    check("R6", "repeat area rewound", 32'(get16(32'h108)), 32'h0820);
    check("R6", "repeat count reloaded", 32'(get16(32'h10A)), 32'h0202);
    check("R9", "repeat expiry raises no irq", 32'(irq_cnt - i0), 32'd0);
  endtask

  task automatic t_block();
    int i0;
    i0 = irq_cnt;
    make_desc(32'h100, 16'h0025, 24'h000430, 24'h000830, 16'h0303, 16'd1);
    mem[12'h430] = 8'h11;
    mem[12'h431] = 8'h22;
    mem[12'h432] = 8'h33;
    fire(1'b0);
    check("R7", "block bytes moved",
          32'({mem[12'h830], mem[12'h831], mem[12'h832]}), 32'h00112233);
    check("R7", "block area rewound", 32'(get16(32'h104)), 32'h0430);
    check("R7", "other side advanced", 32'(get16(32'h108)), 32'h0833);
    check("R7", "block size reloaded", 32'(get16(32'h10A)), 32'h0303);
    check("R7", "block count decremented", 32'(get16(32'h10C)), 32'd0);
    check("R9", "irq on block expiry", 32'(irq_cnt - i0), 32'd1);
  endtask

  task automatic t_chain();
    int i0;
    int f0;
    i0 = irq_cnt;
    f0 = fall_cnt;
    make_desc(32'h100, 16'h0105, 24'h000440, 24'h000840, 16'd3, 16'd0);
    make_desc(32'h110, 16'h0005, 24'h000450, 24'h000850, 16'd3, 16'd0);
    mem[12'h440] = 8'h5A;
    mem[12'h450] = 8'hC3;
    fire(1'b0);
    check("R8", "first descriptor data", 32'(mem[12'h840]), 32'h5A);
    check("R8", "chained descriptor data", 32'(mem[12'h850]), 32'hC3);
    check("R8", "chained count written back", 32'(get16(32'h11A)), 32'd2);
    check("R2", "busy falls once for a chain", 32'(fall_cnt - f0), 32'd1);
    check("R9", "no irq without expiry", 32'(irq_cnt - i0), 32'd0);
  endtask

  task automatic t_notify();
    int i0;
    i0 = irq_cnt;
    make_desc(32'h100, 16'h0205, 24'h000460, 24'h000860, 16'd5, 16'd0);
    fire(1'b1);
    check("R9", "notify raises irq", 32'(irq_cnt - i0), 32'd1);
    check("R9", "irq gone after pulse", 32'(irq), 32'd0);
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_normal_byte();
    t_word_dec_sw();
    t_zero_count();
    t_repeat();
    t_block();
    t_chain();
    t_notify();
    repeat (3) @(negedge clk);
    summary();
    $finish;
  end

endmodule